// File: doc/BRIEF.md
# Host to Microcontroller Byte Mailbox

This block passes bytes in both directions between a host processor bus and a small microcontroller. The host writes a byte into an inbound latch and reads a byte from an outbound latch. The microcontroller sees two parallel ports. Port A carries the data, and port C carries the handshake. Each port has a data register and a direction register (DDR).

The handshake runs through the effective value of port C. Two bits of that value act as strobes. Bit 2 is the acknowledge strobe. A rising edge on it releases the inbound slot, and its level selects what port A reads as input. Bit 3 is the capture strobe. While it is low, every port C update copies the port A data register into the outbound latch.

Each direction has a two-state machine:
- The inbound machine has the states `H2M_EMPTY` and `H2M_FULL`. It takes the transition *host_load* on a host write, and *ack_release* on a rising edge of the acknowledge bit.
- The outbound machine has the states `M2H_EMPTY` and `M2H_FULL`. It takes the transition *mcu_capture* when the capture bit is low on a port C update, and *host_take* on a host read.

The interrupt request to the microcontroller is high whenever the inbound machine is in `H2M_FULL`.

Top module: `host_mcu_mailbox`

## Requirements
- R1: After reset, the following hold: all port registers are 0, the effective port C value is 0, both machines are empty, `mcu_irq` is 0, `host_rdata` is 0, the port A read is 0x00, and the port C read is 0x02.
- R2: A port A read returns, bit by bit, the data register where DDR A is 1 and the port A input value where DDR A is 0.
- R3: Every write to the port C data register or to the port C DDR forces bits 7..4 of the stored value to 1.
- R4: A host write loads `host_wdata` into the inbound latch and moves the inbound machine to `H2M_FULL`. `h2m_full` and `mcu_irq` are 1 from the next cycle.
- R5: The effective port C value is the port C data register OR the inverted port C DDR. A 0-to-1 change of its bit 2 on a port C update moves the inbound machine to `H2M_EMPTY` and drops `mcu_irq`. If bit 2 stays high, an update does not do this.
- R6: On every port C update, the port A input value is reloaded. It takes the inbound latch if effective bit 2 is low, and 0xFF if it is high. Between updates it holds its value.
- R7: On every port C update whose effective bit 3 is low, the port A data register is copied into `host_rdata` and the outbound machine goes to `M2H_FULL`. This repeats on each such update, not only on a falling edge.
- R8: A port C update is either a port C data write (`mcu_sel`=2), or a port C DDR write (`mcu_sel`=3) whose forced value differs from the stored DDR. A DDR write of an unchanged value has no effect. The other `mcu_sel` codes are: 0 port A data, 1 port A DDR.
- R9: A host read moves the outbound machine to `M2H_EMPTY` and leaves `host_rdata` unchanged.
- R10: A port C read returns the data register on bits whose DDR is 1. On bits whose DDR is 0 it returns a pin value: bit 0 is `h2m_full`, bit 1 is NOT `m2h_full`, and the other bits are 0.
- R11: A host write in the same cycle as an acknowledge rising edge leaves the inbound machine `H2M_FULL`. A capture in the same cycle as a host read leaves the outbound machine `M2H_FULL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for the inbound latch |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe, takes the outbound byte |
| host_rdata | output | 8 | Outbound latch contents |
| mcu_wr | input | 1 | Microcontroller register write strobe |
| mcu_sel | input | 2 | Register select: 0 A data, 1 A DDR, 2 C data, 3 C DDR |
| mcu_wdata | input | 8 | Microcontroller write byte |
| mcu_pa_rdata | output | 8 | Port A read value |
| mcu_pc_rdata | output | 8 | Port C read value |
| h2m_full | output | 1 | Inbound machine is in `H2M_FULL` |
| m2h_full | output | 1 | Outbound machine is in `M2H_FULL` |
| mcu_irq | output | 1 | Interrupt request to the microcontroller |

## Verification
The assertions assume that every strobe is a single-cycle pulse sampled on the rising clock edge. They also assume that `mcu_sel` is valid whenever `mcu_wr` is high. They rely on the fact that the inbound and outbound machines can only be set or cleared through the strobes named in R4, R5, R7 and R9. The stimulus raises each strobe for exactly one cycle, between falling edges. It holds all strobes low while results are sampled. It combines a host strobe with a port C write only in the two deliberate collision cases of R11.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [1:0] {
        SEL_PA_DATA = 2'd0,
        SEL_PA_DDR  = 2'd1,
        SEL_PC_DATA = 2'd2,
        SEL_PC_DDR  = 2'd3
    } mbox_sel_e;

    typedef enum logic {
        H2M_EMPTY = 1'b0,
        H2M_FULL  = 1'b1
    } h2m_state_e;

    typedef enum logic {
        M2H_EMPTY = 1'b0,
        M2H_FULL  = 1'b1
    } m2h_state_e;

    typedef struct packed {
        logic fire;
        logic ack_rise;
        logic ack_low;
        logic stb_low;
    } pc_event_t;

endpackage

// File: rtl/mbox_port_a.sv
module mbox_port_a #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_data_en,
    input  logic          wr_ddr_en,
    input  logic [DW-1:0] wdata,
    input  logic          in_load,
    input  logic [DW-1:0] in_value,
    output logic [DW-1:0] out_reg,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] ddr_q;
    logic [DW-1:0] in_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_reg <= '0;
            ddr_q   <= '0;
            in_q    <= '0;
        end else begin
            if (wr_data_en) out_reg <= wdata;
            if (wr_ddr_en)  ddr_q   <= wdata;
            if (in_load)    in_q    <= in_value;
        end
    end

    // per-bit direction select
    for (genvar b = 0; b < DW; b++) begin : g_rd_bit
        assign rdata[b] = ddr_q[b] ? out_reg[b] : in_q[b];
    end

endmodule

// File: rtl/mbox_port_c.sv
module mbox_port_c
    import mbox_pkg::*;
#(
    parameter int DW      = 8,
    parameter int ACK_BIT = 2,
    parameter int STB_BIT = 3,
    parameter int HF_BIT  = 0,
    parameter int MF_BIT  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_data_en,
    input  logic          wr_ddr_en,
    input  logic [DW-1:0] wdata,
    input  logic          h2m_full,
    input  logic          m2h_full,
    output pc_event_t     evt,
    output logic [DW-1:0] rdata
);

    localparam int HALF = DW / 2;
    localparam logic [DW-1:0] FORCE_MASK = {{(DW-HALF){1'b1}}, {HALF{1'b0}}};

    logic [DW-1:0] int_q, ddr_q, eff_q;
    logic [DW-1:0] int_nx, ddr_nx, eff_nx;
    logic [DW-1:0] pin_val;
    logic          fire;

    always_comb begin
        int_nx = int_q;
        ddr_nx = ddr_q;
        if (wr_data_en) int_nx = wdata | FORCE_MASK;
        if (wr_ddr_en)  ddr_nx = wdata | FORCE_MASK;
        eff_nx = int_nx | ~ddr_nx;
    end

    assign fire = wr_data_en | (wr_ddr_en & (ddr_nx != ddr_q));

    always_comb begin
        evt.fire     = fire;
        evt.ack_rise = fire & ~eff_q[ACK_BIT] & eff_nx[ACK_BIT];
        evt.ack_low  = ~eff_nx[ACK_BIT];
        evt.stb_low  = fire & ~eff_nx[STB_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q <= '0;
            ddr_q <= '0;
            eff_q <= '0;
        end else begin
            int_q <= int_nx;
            ddr_q <= ddr_nx;
            if (fire) eff_q <= eff_nx;
        end
    end

    always_comb begin
        pin_val         = '0;
        pin_val[HF_BIT] = h2m_full;
        pin_val[MF_BIT] = ~m2h_full;
    end

    for (genvar b = 0; b < DW; b++) begin : g_rd_bit
        assign rdata[b] = ddr_q[b] ? int_q[b] : pin_val[b];
    end

endmodule

// File: rtl/mbox_flags.sv
module mbox_flags
    import mbox_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_rd,
    input  pc_event_t     evt,
    input  logic [DW-1:0] pa_out,
    output logic [DW-1:0] h2m_data,
    output logic [DW-1:0] m2h_data,
    output logic          h2m_full,
    output logic          m2h_full,
    output logic          irq
);

    h2m_state_e h2m_st, h2m_nx;
    m2h_state_e m2h_st, m2h_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h2m_st <= H2M_EMPTY;
            m2h_st <= M2H_EMPTY;
        end else begin
            h2m_st <= h2m_nx;
            m2h_st <= m2h_nx;
        end
    end

    always_comb begin
        h2m_nx = h2m_st;
        unique case (h2m_st)
            H2M_EMPTY: if (host_wr) h2m_nx = H2M_FULL;
            H2M_FULL:  if (!host_wr && evt.ack_rise) h2m_nx = H2M_EMPTY;
        endcase
    end

    always_comb begin
        m2h_nx = m2h_st;
        unique case (m2h_st)
            M2H_EMPTY: if (evt.stb_low) m2h_nx = M2H_FULL;
            M2H_FULL:  if (!evt.stb_low && host_rd) m2h_nx = M2H_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h2m_data <= '0;
            m2h_data <= '0;
        end else begin
            if (host_wr)     h2m_data <= host_wdata;
            if (evt.stb_low) m2h_data <= pa_out;
        end
    end

    always_comb begin
        h2m_full = (h2m_st == H2M_FULL);
        irq      = (h2m_st == H2M_FULL);
        m2h_full = (m2h_st == M2H_FULL);
    end

endmodule

// File: rtl/host_mcu_mailbox.sv
module host_mcu_mailbox
    import mbox_pkg::*;
#(
    parameter int DW      = 8,
    parameter int ACK_BIT = 2,
    parameter int STB_BIT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_rd,
    output logic [DW-1:0] host_rdata,
    input  logic          mcu_wr,
    input  logic [1:0]    mcu_sel,
    input  logic [DW-1:0] mcu_wdata,
    output logic [DW-1:0] mcu_pa_rdata,
    output logic [DW-1:0] mcu_pc_rdata,
    output logic          h2m_full,
    output logic          m2h_full,
    output logic          mcu_irq
);

    mbox_sel_e     sel;
    logic          pa_data_we, pa_ddr_we, pc_data_we, pc_ddr_we;
    pc_event_t     evt;
    logic [DW-1:0] pa_out, h2m_data, pa_in_val;

    assign sel = mbox_sel_e'(mcu_sel);

    always_comb begin
        pa_data_we = 1'b0;
        pa_ddr_we  = 1'b0;
        pc_data_we = 1'b0;
        pc_ddr_we  = 1'b0;
        if (mcu_wr) begin
            unique case (sel)
                SEL_PA_DATA: pa_data_we = 1'b1;
                SEL_PA_DDR:  pa_ddr_we  = 1'b1;
                SEL_PC_DATA: pc_data_we = 1'b1;
                SEL_PC_DDR:  pc_ddr_we  = 1'b1;
            endcase
        end
    end

    assign pa_in_val = evt.ack_low ? h2m_data : '1;

    mbox_port_a #(.DW(DW)) u_port_a (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_data_en (pa_data_we),
        .wr_ddr_en  (pa_ddr_we),
        .wdata      (mcu_wdata),
        .in_load    (evt.fire),
        .in_value   (pa_in_val),
        .out_reg    (pa_out),
        .rdata      (mcu_pa_rdata)
    );

    mbox_port_c #(
        .DW      (DW),
        .ACK_BIT (ACK_BIT),
        .STB_BIT (STB_BIT),
        .HF_BIT  (0),
        .MF_BIT  (1)
    ) u_port_c (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_data_en (pc_data_we),
        .wr_ddr_en  (pc_ddr_we),
        .wdata      (mcu_wdata),
        .h2m_full   (h2m_full),
        .m2h_full   (m2h_full),
        .evt        (evt),
        .rdata      (mcu_pc_rdata)
    );

    mbox_flags #(.DW(DW)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rd    (host_rd),
        .evt        (evt),
        .pa_out     (pa_out),
        .h2m_data   (h2m_data),
        .m2h_data   (host_rdata),
        .h2m_full   (h2m_full),
        .m2h_full   (m2h_full),
        .irq        (mcu_irq)
    );

endmodule

// File: rtl/host_mcu_mailbox_chk.sv
module host_mcu_mailbox_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_wr,
    input logic          host_rd,
    input logic [DW-1:0] host_rdata,
    input logic          mcu_wr,
    input logic [1:0]    mcu_sel,
    input logic [DW-1:0] mcu_pc_rdata,
    input logic          h2m_full,
    input logic          m2h_full
);

    localparam int HALF = DW / 2;

    logic seen_pc_data, seen_pc_ddr, pc_wr;

    assign pc_wr = mcu_wr && mcu_sel[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_pc_data <= 1'b0;
            seen_pc_ddr  <= 1'b0;
        end else if (mcu_wr) begin
            if (mcu_sel == 2'd2) seen_pc_data <= 1'b1;
            if (mcu_sel == 2'd3) seen_pc_ddr  <= 1'b1;
        end
    end

    // R4
    a_r4_host_wr_fills: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> h2m_full);

    // R5
    a_r5_release_needs_portc: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(h2m_full) |-> $past(pc_wr));

    // R7
    a_r7_capture_needs_portc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m2h_full) |-> $past(pc_wr));

    // R9
    a_r9_host_rd_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !pc_wr) |=> !m2h_full);

    // R9
    a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_wr |=> $stable(host_rdata));

    // R3
    a_r3_upper_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_pc_data && seen_pc_ddr) |-> (mcu_pc_rdata[DW-1:HALF] == '1));

endmodule

bind host_mcu_mailbox host_mcu_mailbox_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr      (host_wr),
    .host_rd      (host_rd),
    .host_rdata   (host_rdata),
    .mcu_wr       (mcu_wr),
    .mcu_sel      (mcu_sel),
    .mcu_pc_rdata (mcu_pc_rdata),
    .h2m_full     (h2m_full),
    .m2h_full     (m2h_full)
);

// File: tb/host_mcu_mailbox_bench.sv
module host_mcu_mailbox_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0, mcu_wr = 1'b0;
    logic [7:0] host_wdata = '0, mcu_wdata = '0;
    logic [1:0] mcu_sel = '0;
    logic [7:0] host_rdata, mcu_pa_rdata, mcu_pc_rdata;
    logic       h2m_full, m2h_full, mcu_irq;

    localparam int S_RDATA = 0, S_PA = 1, S_PC = 2, S_FLAGS = 3;

    typedef struct {
        string      req;
        int         sig;
        logic [7:0] exp;
    } item_t;

    item_t q[$];
    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;

    always #4 clk = ~clk;

    host_mcu_mailbox u_host_mcu_mailbox (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr      (host_wr),
        .host_wdata   (host_wdata),
        .host_rd      (host_rd),
        .host_rdata   (host_rdata),
        .mcu_wr       (mcu_wr),
        .mcu_sel      (mcu_sel),
        .mcu_wdata    (mcu_wdata),
        .mcu_pa_rdata (mcu_pa_rdata),
        .mcu_pc_rdata (mcu_pc_rdata),
        .h2m_full     (h2m_full),
        .m2h_full     (m2h_full),
        .mcu_irq      (mcu_irq)
    );

    function automatic logic [7:0] observe(int sig);
        case (sig)
            S_RDATA: return host_rdata;
            S_PA:    return mcu_pa_rdata;
            S_PC:    return mcu_pc_rdata;
            default: return {5'b0, mcu_irq, m2h_full, h2m_full};
        endcase
    endfunction

    // monitor: pops expectations and compares, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = q.pop_front();
                act = observe(it.sig);
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s sig=%0d actual=%02h expected=%02h", it.req, it.sig, act, it.exp);
                end
            end
        end
    end

    task automatic push(string req, int sig, logic [7:0] exp);
        item_t it;
        it.req = req;
        it.sig = sig;
        it.exp = exp;
        q.push_back(it);
    endtask

    task automatic settle();
        @(posedge clk);
        #3;
    endtask

    task automatic drive(logic hw, logic [7:0] hd, logic hr, logic mw, logic [1:0] sel, logic [7:0] md);
        @(negedge clk);
        host_wr = hw; host_wdata = hd; host_rd = hr;
        mcu_wr = mw; mcu_sel = sel; mcu_wdata = md;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0; mcu_wr = 1'b0;
    endtask

    task automatic mcu_write(logic [1:0] sel, logic [7:0] d);
        drive(1'b0, 8'h00, 1'b0, 1'b1, sel, d);
    endtask

    task automatic host_write(logic [7:0] d);
        drive(1'b1, d, 1'b0, 1'b0, 2'd0, 8'h00);
    endtask

    task automatic host_read();
        drive(1'b0, 8'h00, 1'b1, 1'b0, 2'd0, 8'h00);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        push("R1", S_RDATA, 8'h00);
        push("R1", S_PA, 8'h00);
        push("R1", S_PC, 8'h02);
        push("R1", S_FLAGS, 8'h00);
        settle();

        // R4, R10: host write fills inbound slot
        host_write(8'h5A);
        push("R4", S_FLAGS, 8'h05);
        push("R10", S_PC, 8'h03);
        settle();

        // R2: mixed direction port A
        mcu_write(2'd1, 8'hF0);
        mcu_write(2'd0, 8'h3C);
        push("R2", S_PA, 8'h30);
        settle();

        // R8, R6, R7: DDR change is an update; bit2 low, bit3 low
        mcu_write(2'd3, 8'h0C);
        push("R6", S_PA, 8'h3A);
        push("R7", S_RDATA, 8'h3C);
        push("R7", S_FLAGS, 8'h07);
        push("R10", S_PC, 8'h01);
        settle();

        // R8: unchanged DDR write has no effect
        mcu_write(2'd0, 8'h81);
        mcu_write(2'd3, 8'h0C);
        push("R8", S_RDATA, 8'h3C);
        push("R2", S_PA, 8'h8A);
        settle();

        // R9: host read empties, data held
        host_read();
        push("R9", S_FLAGS, 8'h05);
        push("R9", S_RDATA, 8'h3C);
        settle();

        // R5, R3, R6, R7: rising ack bit
        mcu_write(2'd2, 8'h04);
        push("R5", S_FLAGS, 8'h02);
        push("R7", S_RDATA, 8'h81);
        push("R6", S_PA, 8'h8F);
        push("R3", S_PC, 8'hF4);
        settle();

        // R5 no edge, R7 level capture repeats
        host_write(8'h11);
        host_read();
        push("R4", S_FLAGS, 8'h05);
        settle();
        mcu_write(2'd0, 8'h42);
        mcu_write(2'd2, 8'h04);
        push("R5", S_FLAGS, 8'h07);
        push("R7", S_RDATA, 8'h42);
        push("R6", S_PA, 8'h4F);
        settle();

        // R7 no capture with bit3 high, R6 ack low shows latch
        mcu_write(2'd0, 8'h99);
        mcu_write(2'd2, 8'h08);
        push("R7", S_RDATA, 8'h42);
        push("R6", S_PA, 8'h91);
        push("R5", S_FLAGS, 8'h07);
        settle();

        // R11: host write collides with ack rising edge
        drive(1'b1, 8'h77, 1'b0, 1'b1, 2'd2, 8'h0C);
        push("R11", S_FLAGS, 8'h07);
        push("R11", S_RDATA, 8'h42);
        push("R6", S_PA, 8'h9F);
        settle();

        // R11: capture collides with host read
        drive(1'b0, 8'h00, 1'b1, 1'b1, 2'd2, 8'h00);
        push("R11", S_FLAGS, 8'h07);
        push("R11", S_RDATA, 8'h99);
        push("R6", S_PA, 8'h97);
        settle();

        // R8: DDR change gives ack rising edge
        mcu_write(2'd3, 8'h08);
        push("R8", S_FLAGS, 8'h02);
        push("R6", S_PA, 8'h9F);
        push("R10", S_PC, 8'hF0);
        settle();

        host_read();
        push("R9", S_FLAGS, 8'h00);
        push("R10", S_PC, 8'hF2);
        settle();

        settle();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule